// File: doc/BRIEF.md
# In-Order Vector Issue Queue

This block sits between instruction dispatch and the vector execution units of an out-of-order core. It buffers up to four decoded vector operations. Each operation carries a two-bit code that names the kind of unit it needs and an eight-bit tag that travels with it. Dispatch may present up to two operations per cycle. The queue accepts them oldest lane first, as far as its free space allows, and appends them behind the entries already held.

Each cycle the queue may send up to two operations to the four vector units, and only from its two oldest slots. Issue is strictly in program order. The oldest entry leaves when its unit reports ready. The second-oldest may leave in the same cycle only if the oldest also leaves, its own unit is ready, and it needs a different unit. Entries that remain slide down toward slot zero. A flush input discards every entry.

A small state machine tracks the occupancy class. It has three states: EMPTY, PARTIAL and FULL. Its transitions are fill (EMPTY to PARTIAL or FULL), top-up (PARTIAL to FULL), drain (PARTIAL or FULL to EMPTY), partial drain (FULL to PARTIAL) and flush (any state to EMPTY). In every other case the state holds. The free-slot count offered to dispatch comes from this state.

Top module: `vec_issue_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, the queue is empty: `free_slots` is 4 and `iss_valid` is 0.
- R2: Write lanes are taken in age order, lane 0 before lane 1. An accepted lane is flagged in `wr_accept` and is placed behind every entry already held. If only lane 1 is valid, it is accepted alone.
- R3: Issue lane 0 is valid exactly when the queue holds an entry, no flush is applied, and the oldest entry's unit has its `unit_ready` bit set.
- R4: Issue lane 1 is valid only when lane 0 is valid in the same cycle, at least two entries are held, the second entry's unit is ready, and its unit code differs from the oldest entry's unit code.
- R5: Issue lane 0 carries the unit code and tag of the oldest entry. Issue lane 1 carries the unit code and tag of the second-oldest entry.
- R6: After issuing n entries, the remaining entries keep their relative order and become the oldest, ahead of the writes accepted in the same cycle.
- R7: `free_slots` equals 4 minus the entries held, plus the number issuing in this cycle.
- R8: A write lane is accepted only while free slots remain after the earlier lanes of the same cycle. The queue never holds more than four entries.
- R9: With `flush` high, no lane issues and no write is accepted. In the next cycle the queue is empty.
- R10: Unit codes are 0 permute, 1 simple integer, 2 complex integer and 3 floating point. Bit c of `unit_ready` is the ready signal of the unit with code c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all held entries |
| wr_valid | input | 2 | Per-lane write request from dispatch |
| wr_unit | input | 4 | Per-lane unit code, lane k in bits [2k+1:2k] |
| wr_tag | input | 16 | Per-lane tag, lane k in bits [8k+7:8k] |
| wr_accept | output | 2 | Per-lane write taken this cycle |
| free_slots | output | 3 | Slots available to writes this cycle |
| unit_ready | input | 4 | Ready signal per vector unit, indexed by unit code |
| iss_valid | output | 2 | Per-lane issue this cycle |
| iss_unit | output | 4 | Unit code of each issuing lane |
| iss_tag | output | 16 | Tag of each issuing lane |

## Verification
The issue outputs, `free_slots` and `wr_accept` are combinational in the held entries and the inputs of the current cycle. They are therefore due in the same cycle as the stimulus. The bench drives the inputs one nanosecond after a rising edge and compares these outputs at the falling edge. Held contents change only at the next rising edge, so each compare applies a cycle's issue and writes to a bench-side model. The compares of the following cycle then check the compaction and the one-cycle flush through the tags and units that come out next.

// File: rtl/vq_pkg.sv
package vq_pkg;
    localparam int UNIT_W    = 2;
    localparam int NUM_UNITS = 4;
    localparam int TAG_W     = 8;

    // Unit codes (R10): bit index into unit_ready equals the code.
    typedef enum logic [UNIT_W-1:0] {
        UNIT_PERM = 2'd0,
        UNIT_SINT = 2'd1,
        UNIT_CINT = 2'd2,
        UNIT_VFP  = 2'd3
    } vunit_e;

    typedef struct packed {
        vunit_e             unit;
        logic [TAG_W-1:0]   tag;
    } vq_entry_t;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;
endpackage

// File: rtl/vq_issue_sel.sv
module vq_issue_sel
    import vq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int ISS_W = 2,
    parameter int CW    = 3
) (
    input  vq_entry_t              ents [DEPTH],
    input  logic [CW-1:0]          count,
    input  logic                   flush,
    input  logic [NUM_UNITS-1:0]   unit_ready,
    output logic [ISS_W-1:0]       iss_valid,
    output logic [CW-1:0]          n_iss
);
    logic                 chain;
    logic                 go;
    logic [NUM_UNITS-1:0] taken;

    // Strict in-order selection: a lane may go only if every older lane goes.
    always_comb begin
        chain     = !flush;
        taken     = '0;
        n_iss     = '0;
        iss_valid = '0;
        for (int k = 0; k < ISS_W; k++) begin
            go = chain && (CW'(k) < count)
                 && unit_ready[ents[k].unit]
                 && !taken[ents[k].unit];
            iss_valid[k] = go;
            if (go) begin
                taken[ents[k].unit] = 1'b1;
                n_iss = n_iss + CW'(1);
            end
            chain = go;
        end
    end
endmodule

// File: rtl/vq_write_alloc.sv
module vq_write_alloc #(
    parameter int WR_W = 2,
    parameter int CW   = 3
) (
    input  logic [WR_W-1:0] wr_valid,
    input  logic [CW-1:0]   free_slots,
    input  logic            flush,
    output logic [WR_W-1:0] wr_accept,
    output logic [CW-1:0]   n_wr
);
    logic [CW-1:0] room;

    // Lanes are granted oldest first until the room left after issue is used.
    always_comb begin
        room      = flush ? '0 : free_slots;
        n_wr      = '0;
        wr_accept = '0;
        for (int k = 0; k < WR_W; k++) begin
            if (wr_valid[k] && (n_wr < room)) begin
                wr_accept[k] = 1'b1;
                n_wr = n_wr + CW'(1);
            end
        end
    end
endmodule

// File: rtl/vq_storage.sv
module vq_storage
    import vq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WR_W  = 2,
    parameter int CW    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [CW-1:0]   count,
    input  logic [CW-1:0]   n_iss,
    input  logic [WR_W-1:0] wr_accept,
    input  vq_entry_t       wr_ent [WR_W],
    output vq_entry_t       ents   [DEPTH]
);
    vq_entry_t     nxt [DEPTH];
    logic [CW-1:0] base;
    int            src;
    int            pos;

    always_comb begin
        base = count - n_iss;
        for (int i = 0; i < DEPTH; i++) begin
            nxt[i] = ents[i];
            src    = i + int'(n_iss);
            if (src < int'(count) && src < DEPTH)
                nxt[i] = ents[src];
        end
        pos = int'(base);
        for (int k = 0; k < WR_W; k++) begin
            if (wr_accept[k]) begin
                if (pos < DEPTH)
                    nxt[pos] = wr_ent[k];
                pos = pos + 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < DEPTH; i++)
                ents[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                ents[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/vec_issue_queue.sv
module vec_issue_queue
    import vq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WR_W  = 2,
    parameter int ISS_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [WR_W-1:0]           wr_valid,
    input  logic [WR_W*UNIT_W-1:0]    wr_unit,
    input  logic [WR_W*TAG_W-1:0]     wr_tag,
    output logic [WR_W-1:0]           wr_accept,
    output logic [$clog2(DEPTH+1)-1:0] free_slots,
    input  logic [NUM_UNITS-1:0]      unit_ready,
    output logic [ISS_W-1:0]          iss_valid,
    output logic [ISS_W*UNIT_W-1:0]   iss_unit,
    output logic [ISS_W*TAG_W-1:0]    iss_tag
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    occ_state_e    state, state_nxt;
    logic [CW-1:0] count, count_nxt;
    logic [CW-1:0] n_iss, n_wr, room_base;
    vq_entry_t     ents   [DEPTH];
    vq_entry_t     wr_ent [WR_W];

    generate
        for (genvar k = 0; k < WR_W; k++) begin : g_wr_lane
            assign wr_ent[k].unit = vunit_e'(wr_unit[k*UNIT_W +: UNIT_W]);
            assign wr_ent[k].tag  = wr_tag[k*TAG_W +: TAG_W];
        end
        for (genvar k = 0; k < ISS_W; k++) begin : g_iss_lane
            assign iss_unit[k*UNIT_W +: UNIT_W] = ents[k].unit;
            assign iss_tag[k*TAG_W +: TAG_W]    = ents[k].tag;
        end
    endgenerate

    vq_issue_sel #(.DEPTH(DEPTH), .ISS_W(ISS_W), .CW(CW)) u_sel (
        .ents       (ents),
        .count      (count),
        .flush      (flush),
        .unit_ready (unit_ready),
        .iss_valid  (iss_valid),
        .n_iss      (n_iss)
    );

    vq_write_alloc #(.WR_W(WR_W), .CW(CW)) u_alloc (
        .wr_valid   (wr_valid),
        .free_slots (free_slots),
        .flush      (flush),
        .wr_accept  (wr_accept),
        .n_wr       (n_wr)
    );

    vq_storage #(.DEPTH(DEPTH), .WR_W(WR_W), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .count     (count),
        .n_iss     (n_iss),
        .wr_accept (wr_accept),
        .wr_ent    (wr_ent),
        .ents      (ents)
    );

    assign count_nxt = flush ? '0 : (count - n_iss + n_wr);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    // Transitions: fill, top-up, drain, partial drain, flush.
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: begin
                if (flush)                       state_nxt = OCC_EMPTY;
                else if (count_nxt == DEPTH_C)   state_nxt = OCC_FULL;
                else if (count_nxt != '0)        state_nxt = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (flush)                       state_nxt = OCC_EMPTY;
                else if (count_nxt == DEPTH_C)   state_nxt = OCC_FULL;
                else if (count_nxt == '0)        state_nxt = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (flush)                       state_nxt = OCC_EMPTY;
                else if (count_nxt == '0)        state_nxt = OCC_EMPTY;
                else if (count_nxt != DEPTH_C)   state_nxt = OCC_PARTIAL;
            end
            default:                             state_nxt = OCC_EMPTY;
        endcase
    end

    // Outputs: room offered to dispatch, widened by this cycle's issue.
    always_comb begin
        room_base = '0;
        unique case (state)
            OCC_EMPTY:   room_base = DEPTH_C;
            OCC_PARTIAL: room_base = DEPTH_C - count;
            OCC_FULL:    room_base = '0;
            default:     room_base = '0;
        endcase
        free_slots = room_base + n_iss;
    end
endmodule

// File: rtl/vq_checker.sv
module vq_checker
    import vq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int ISS_W = 2,
    parameter int CW    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic [ISS_W-1:0]        iss_valid,
    input logic [ISS_W*UNIT_W-1:0] iss_unit,
    input logic [NUM_UNITS-1:0]    unit_ready,
    input logic [CW-1:0]           free_slots,
    input logic [CW-1:0]           count
);
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r7_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= CW'(DEPTH));

    a_r3_head_unit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |-> unit_ready[iss_unit[UNIT_W-1:0]]);

    a_r9_flush_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (iss_valid == '0));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    generate
        if (ISS_W >= 2) begin : g_pair
            a_r4_in_order: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[1] |-> iss_valid[0]);

            a_r4_distinct_units: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[1] |-> (iss_unit[UNIT_W +: UNIT_W] != iss_unit[UNIT_W-1:0]));
        end
    endgenerate
endmodule

bind vec_issue_queue vq_checker #(.DEPTH(DEPTH), .ISS_W(ISS_W), .CW(CW)) u_vq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .iss_valid  (iss_valid),
    .iss_unit   (iss_unit),
    .unit_ready (unit_ready),
    .free_slots (free_slots),
    .count      (count)
);

// File: tb/test_vec_issue_queue.sv
module test_vec_issue_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  wr_valid = '0;
    logic [3:0]  wr_unit = '0;
    logic [15:0] wr_tag = '0;
    logic [1:0]  wr_accept;
    logic [2:0]  free_slots;
    logic [3:0]  unit_ready = '0;
    logic [1:0]  iss_valid;
    logic [3:0]  iss_unit;
    logic [15:0] iss_tag;

    int total = 0;
    int bad   = 0;

    // Bench-side model of held entries.
    int m_unit [4];
    int m_tag  [4];
    int m_cnt = 0;
    logic [7:0]  tag_seq = 8'h10;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #2 clk = ~clk;

    vec_issue_queue i_vec_issue_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_valid(wr_valid), .wr_unit(wr_unit), .wr_tag(wr_tag),
        .wr_accept(wr_accept), .free_slots(free_slots),
        .unit_ready(unit_ready), .iss_valid(iss_valid),
        .iss_unit(iss_unit), .iss_tag(iss_tag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, compare outputs mid-cycle, advance model, reach next edge.
    task automatic step(input logic fl, input logic [1:0] wv,
                        input logic [1:0] ua, input logic [1:0] ub,
                        input logic [3:0] rdy);
        int          n;
        int          room;
        int          acc;
        logic        chain;
        logic        go;
        logic [3:0]  used;
        logic [1:0]  e_iss;
        logic [1:0]  e_acc;
        int          nu [4];
        int          nt [4];
        logic [7:0]  ta;
        logic [7:0]  tb;
        ta = tag_seq; tb = tag_seq + 8'd1; tag_seq = tag_seq + 8'd2;
        flush = fl; wr_valid = wv; wr_unit = {ub, ua}; wr_tag = {tb, ta}; unit_ready = rdy;
        #1;
        chain = !fl; used = '0; n = 0; e_iss = '0;
        for (int k = 0; k < 2; k++) begin
            go = chain && (k < m_cnt) && rdy[m_unit[k]] && !used[m_unit[k]];
            e_iss[k] = go;
            if (go) begin used[m_unit[k]] = 1'b1; n++; end
            chain = go;
        end
        chk(fl ? "R9 flush issue" : "R3 lane0 issue", 32'(iss_valid[0]), 32'(e_iss[0]));
        chk(fl ? "R9 flush issue" : "R4 lane1 issue", 32'(iss_valid[1]), 32'(e_iss[1]));
        for (int k = 0; k < 2; k++) begin
            if (e_iss[k]) begin
                chk("R5 R10 issue unit", 32'(iss_unit[2*k +: 2]), 32'(m_unit[k]));
                chk("R5 R6 issue tag", 32'(iss_tag[8*k +: 8]), 32'(m_tag[k]));
            end
        end
        chk("R7 free slots", 32'(free_slots), 32'(4 - m_cnt + n));
        room = fl ? 0 : (4 - m_cnt + n);
        acc = 0; e_acc = '0;
        for (int k = 0; k < 2; k++) begin
            if (wv[k] && acc < room) begin e_acc[k] = 1'b1; acc++; end
        end
        chk(fl ? "R9 flush write" : "R2 R8 write accept", 32'(wr_accept), 32'(e_acc));
        if (fl) begin
            m_cnt = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin nu[i] = 0; nt[i] = 0; end
            for (int i = 0; i + n < m_cnt; i++) begin
                nu[i] = m_unit[i + n]; nt[i] = m_tag[i + n];
            end
            m_cnt = m_cnt - n;
            if (e_acc[0]) begin nu[m_cnt] = int'(ua); nt[m_cnt] = int'(ta); m_cnt++; end
            if (e_acc[1]) begin nu[m_cnt] = int'(ub); nt[m_cnt] = int'(tb); m_cnt++; end
            for (int i = 0; i < 4; i++) begin m_unit[i] = nu[i]; m_tag[i] = nt[i]; end
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset free", 32'(free_slots), 32'd4);
        chk("R1 reset issue", 32'(iss_valid), 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 after reset free", 32'(free_slots), 32'd4);
        chk("R1 after reset issue", 32'(iss_valid), 32'd0);
        @(posedge clk); #1;

        // R8: overflow with every unit stalled; third pair must be refused.
        step(1'b0, 2'b11, 2'd0, 2'd1, 4'h0);
        step(1'b0, 2'b11, 2'd2, 2'd3, 4'h0);
        step(1'b0, 2'b11, 2'd1, 2'd2, 4'h0);
        // R4: head blocked, second ready; nothing may leave.
        step(1'b0, 2'b00, 2'd0, 2'd0, 4'b0010);
        // R7: issue two while full, refill two in the same cycle.
        step(1'b0, 2'b11, 2'd3, 2'd3, 4'hF);
        // R2: only lane 1 valid.
        step(1'b0, 2'b10, 2'd0, 2'd1, 4'h0);
        // R9: flush with a full queue.
        step(1'b1, 2'b11, 2'd0, 2'd1, 4'hF);
        step(1'b0, 2'b00, 2'd0, 2'd0, 4'hF);

        // Sweep: every unit pair against every ready pattern (R3 R4 R10).
        for (int p = 0; p < 16; p++) begin
            for (int r = 0; r < 16; r++) begin
                step(1'b1, 2'b00, 2'd0, 2'd0, 4'h0);
                step(1'b0, 2'b11, 2'(p), 2'(p >> 2), 4'h0);
                step(1'b0, 2'b00, 2'd0, 2'd0, 4'(r));
                step(1'b0, 2'b00, 2'd0, 2'd0, 4'hF);
            end
        end

        // Pseudo-random traffic with occasional flush (R2 R5 R6 R7 R8 R9).
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[15:10] == 6'd0, lfsr[1:0], lfsr[3:2], lfsr[5:4],
                 lfsr[16] ? 4'hF : lfsr[9:6]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule